// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

A 32-bit processor core that completes one instruction on every rising clock edge. It fetches the word at the program counter from an internal instruction store and decodes it with purely combinational control. It reads two operands from a 32-entry register file and runs them through an ALU that also judges branch conditions. It then commits at most one register write and at most one data-store write at the same edge that loads the next program counter. Integer ALU operations, word loads and stores, four conditional branches, and direct and register-indirect jumps (with and without a link) are supported. Unrecognised encodings behave as no-operations.

Both word stores sit inside the core and are filled through a preload port while reset is held. Each preload beat is taken in the cycle it is presented and there is no back-pressure, so no valid/ready pair is needed. Every commit is mirrored on plain trace outputs: the register write port, the data-store strobes, address and write data, and the current program counter. An environment can follow execution from these outputs without reaching into the core.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0. During reset, `rf_we_o`, `dm_re_o` and `dm_we_o` stay low, and preload beats (`pl_we`, `pl_sel` 0 = instruction store, 1 = data store, byte address `pl_addr`) are written.
- R2: Opcode 0 selects the operation by funct (ADD 32, SUB 34, AND 36, OR 37, XOR 38, NOR 39, SLT 42 signed, SLTU 43, SLL 0, SRL 2, SRA 3, with the shift amount in bits 10:6 applied to rt). The result is written to rd (bits 15:11).
- R3: Immediate opcodes ADDI 8, SLTI 10, ANDI 12, ORI 13, XORI 14 and LUI 15 take rs (bits 25:21) and the sign-extended bits 15:0, and write rt (bits 20:16). LUI writes the immediate into the upper half with zeros below.
- R4: Register 0 always reads as zero. A write aimed at it still appears on the trace port but leaves no value behind.
- R5: LW (opcode 35) raises `dm_re_o` with address rs + sign-extended immediate and writes the loaded word into rt. No other instruction raises `dm_re_o`.
- R6: SW (opcode 43) raises `dm_we_o` at address rs + sign-extended immediate with the rt value as data. It never writes a register, and no other instruction raises `dm_we_o`.
- R7: BEQ 4 and BNE 5 compare rs with rt. BLEZ 6 and BGTZ 7 compare signed rs with zero. A branch that holds goes to PC+4 + (sign-extended immediate × 4), including backward offsets; otherwise execution goes to PC+4. Branches write no register.
- R8: J 2 and JAL 3 go to {PC+4 bits 31:28, target bits 25:0, 00}. JAL also writes PC+4 into register 31.
- R9: Funct 8 (register jump) and funct 9 (register jump with link) go to the rs value. The linking form writes PC+4 into rd; the plain form writes nothing.
- R10: Every other instruction advances the program counter by 4, and each instruction produces only the trace events listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset; also opens the preload port |
| pl_we | input | 1 | Preload write strobe, honoured only during reset |
| pl_sel | input | 1 | Preload target: 0 instruction store, 1 data store |
| pl_addr | input | 32 | Preload byte address (word aligned) |
| pl_data | input | 32 | Preload word |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | Register write commits at the next edge |
| rf_wa_o | output | 5 | Register write index |
| rf_wd_o | output | 32 | Register write data |
| dm_re_o | output | 1 | Data-store read of a load this cycle |
| dm_we_o | output | 1 | Data-store write commits at the next edge |
| dm_addr_o | output | 32 | Data-store byte address (ALU result) |
| dm_wd_o | output | 32 | Data-store write data |

## Verification
On every clock, the embedded properties check several fixed relations. Reset zeroes the program counter, and register 0 keeps its zero. A store never coincides with a register write, a load always writes back the word read, and link writes carry PC+4. Any non-control instruction moves the counter by exactly 4. Whether each ALU result, each branch direction and each jump target is correct can only be shown by the bench program: its writes are predicted by hand in order, and a single wrong value, missing write or extra write shifts the comparison.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;

  // opcodes
  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_J     = 6'd2;
  localparam logic [5:0] OP_JAL   = 6'd3;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_BLEZ  = 6'd6;
  localparam logic [5:0] OP_BGTZ  = 6'd7;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_SLTI  = 6'd10;
  localparam logic [5:0] OP_ANDI  = 6'd12;
  localparam logic [5:0] OP_ORI   = 6'd13;
  localparam logic [5:0] OP_XORI  = 6'd14;
  localparam logic [5:0] OP_LUI   = 6'd15;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  // function codes for opcode 0
  localparam logic [5:0] FN_SLL  = 6'd0;
  localparam logic [5:0] FN_SRL  = 6'd2;
  localparam logic [5:0] FN_SRA  = 6'd3;
  localparam logic [5:0] FN_JR   = 6'd8;
  localparam logic [5:0] FN_JALR = 6'd9;
  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_SUB  = 6'd34;
  localparam logic [5:0] FN_AND  = 6'd36;
  localparam logic [5:0] FN_OR   = 6'd37;
  localparam logic [5:0] FN_XOR  = 6'd38;
  localparam logic [5:0] FN_NOR  = 6'd39;
  localparam logic [5:0] FN_SLT  = 6'd42;
  localparam logic [5:0] FN_SLTU = 6'd43;

  localparam logic [4:0] LINK_REG = 5'd31;

  typedef enum logic [3:0] {
    AL_ADD, AL_SUB, AL_AND, AL_OR, AL_XOR, AL_NOR, AL_SLT, AL_SLTU,
    AL_SLL, AL_SRL, AL_SRA, AL_LUI, AL_EQ, AL_NE, AL_LEZ, AL_GTZ
  } alu_op_e;

  typedef enum logic [1:0] {DST_RT, DST_RD, DST_LINK} dst_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_PC4} wb_e;
  typedef enum logic [1:0] {FL_SEQ, FL_JUMP, FL_BRANCH, FL_REG} flow_e;

  typedef struct packed {
    alu_op_e alu_op;
    logic    b_imm;
    dst_e    dst;
    wb_e     wb;
    logic    reg_we;
    logic    mem_rd;
    logic    mem_wr;
    flow_e   flow;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl.alu_op = AL_ADD;
    ctrl.b_imm  = 1'b1;
    ctrl.dst    = DST_RT;
    ctrl.wb     = WB_ALU;
    ctrl.reg_we = 1'b0;
    ctrl.mem_rd = 1'b0;
    ctrl.mem_wr = 1'b0;
    ctrl.flow   = FL_SEQ;
    case (opcode)
      OP_RTYPE: begin
        ctrl.b_imm  = 1'b0;
        ctrl.dst    = DST_RD;
        ctrl.reg_we = 1'b1;
        case (funct)
          FN_ADD:  ctrl.alu_op = AL_ADD;
          FN_SUB:  ctrl.alu_op = AL_SUB;
          FN_AND:  ctrl.alu_op = AL_AND;
          FN_OR:   ctrl.alu_op = AL_OR;
          FN_XOR:  ctrl.alu_op = AL_XOR;
          FN_NOR:  ctrl.alu_op = AL_NOR;
          FN_SLT:  ctrl.alu_op = AL_SLT;
          FN_SLTU: ctrl.alu_op = AL_SLTU;
          FN_SLL:  ctrl.alu_op = AL_SLL;
          FN_SRL:  ctrl.alu_op = AL_SRL;
          FN_SRA:  ctrl.alu_op = AL_SRA;
          FN_JR: begin
            ctrl.reg_we = 1'b0;
            ctrl.flow   = FL_REG;
          end
          FN_JALR: begin
            ctrl.wb   = WB_PC4;
            ctrl.flow = FL_REG;
          end
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OP_ADDI: begin ctrl.reg_we = 1'b1; ctrl.alu_op = AL_ADD; end
      OP_SLTI: begin ctrl.reg_we = 1'b1; ctrl.alu_op = AL_SLT; end
      OP_ANDI: begin ctrl.reg_we = 1'b1; ctrl.alu_op = AL_AND; end
      OP_ORI:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = AL_OR;  end
      OP_XORI: begin ctrl.reg_we = 1'b1; ctrl.alu_op = AL_XOR; end
      OP_LUI:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = AL_LUI; end
      OP_LW: begin
        ctrl.reg_we = 1'b1;
        ctrl.mem_rd = 1'b1;
        ctrl.wb     = WB_MEM;
      end
      OP_SW: ctrl.mem_wr = 1'b1;
      OP_BEQ: begin
        ctrl.b_imm  = 1'b0;
        ctrl.alu_op = AL_EQ;
        ctrl.flow   = FL_BRANCH;
      end
      OP_BNE: begin
        ctrl.b_imm  = 1'b0;
        ctrl.alu_op = AL_NE;
        ctrl.flow   = FL_BRANCH;
      end
      OP_BLEZ: begin ctrl.alu_op = AL_LEZ; ctrl.flow = FL_BRANCH; end
      OP_BGTZ: begin ctrl.alu_op = AL_GTZ; ctrl.flow = FL_BRANCH; end
      OP_J:    ctrl.flow = FL_JUMP;
      OP_JAL: begin
        ctrl.flow   = FL_JUMP;
        ctrl.reg_we = 1'b1;
        ctrl.dst    = DST_LINK;
        ctrl.wb     = WB_PC4;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter  int NUM = 32,
  parameter  int W   = 32,
  localparam int AW  = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] regs [NUM];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];

  // R4
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    regs[0] == '0);
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter  int W   = 32,
  localparam int SHW = $clog2(W)
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [SHW-1:0] sh,
  output logic [W-1:0]   y,
  output logic           cond
);
  logic a_zero;
  assign a_zero = (a == '0);

  always_comb begin
    y    = '0;
    cond = 1'b0;
    case (op)
      AL_ADD:  y = a + b;
      AL_SUB:  y = a - b;
      AL_AND:  y = a & b;
      AL_OR:   y = a | b;
      AL_XOR:  y = a ^ b;
      AL_NOR:  y = ~(a | b);
      AL_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      AL_SLTU: y = {{(W-1){1'b0}}, (a < b)};
      AL_SLL:  y = b << sh;
      AL_SRL:  y = b >> sh;
      AL_SRA:  y = $unsigned($signed(b) >>> sh);
      AL_LUI:  y = {b[W/2-1:0], {(W/2){1'b0}}};
      AL_EQ:   cond = (a == b);
      AL_NE:   cond = (a != b);
      AL_LEZ:  cond = a[W-1] | a_zero;
      AL_GTZ:  cond = ~a[W-1] & ~a_zero;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter  int DEPTH = 64,
  parameter  int W     = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pl_we,
  input  logic            pl_sel,
  input  logic [XLEN-1:0] pl_addr,
  input  logic [XLEN-1:0] pl_data,
  output logic [XLEN-1:0] pc_o,
  output logic            rf_we_o,
  output logic [4:0]      rf_wa_o,
  output logic [XLEN-1:0] rf_wd_o,
  output logic            dm_re_o,
  output logic            dm_we_o,
  output logic [XLEN-1:0] dm_addr_o,
  output logic [XLEN-1:0] dm_wd_o
);
  localparam int IAW = $clog2(IMEM_DEPTH);
  localparam int DAW = $clog2(DMEM_DEPTH);

  logic [XLEN-1:0] pc_q, pc_d, pc4, br_tgt, j_tgt;
  logic [XLEN-1:0] instr, simm, rs_val, rt_val, alu_b, alu_y, ld_data;
  logic            cond;
  ctrl_t           ctrl;
  logic            pl_go;
  logic            unused_pl;

  // instruction fields
  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd, shamt;
  logic [15:0] imm16;
  logic [25:0] tgt26;
  assign opcode = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign shamt  = instr[10:6];
  assign funct  = instr[5:0];
  assign imm16  = instr[15:0];
  assign tgt26  = instr[25:0];
  assign simm   = {{(XLEN-16){imm16[15]}}, imm16};

  assign pl_go     = rst & pl_we;
  assign unused_pl = ^pl_addr;

  sc_mem #(.DEPTH(IMEM_DEPTH), .W(XLEN)) u_imem (
    .clk   (clk),
    .we    (pl_go & ~pl_sel),
    .waddr (pl_addr[IAW+1:2]),
    .wdata (pl_data),
    .raddr (pc_q[IAW+1:2]),
    .rdata (instr)
  );

  sc_decode u_dec (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  sc_regfile #(.NUM(NREG), .W(XLEN)) u_rf (
    .clk (clk),
    .rst (rst),
    .we  (rf_we_o),
    .wa  (rf_wa_o),
    .wd  (rf_wd_o),
    .ra1 (rs),
    .rd1 (rs_val),
    .ra2 (rt),
    .rd2 (rt_val)
  );

  assign alu_b = ctrl.b_imm ? simm : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .op   (ctrl.alu_op),
    .a    (rs_val),
    .b    (alu_b),
    .sh   (shamt),
    .y    (alu_y),
    .cond (cond)
  );

  sc_mem #(.DEPTH(DMEM_DEPTH), .W(XLEN)) u_dmem (
    .clk   (clk),
    .we    ((pl_go & pl_sel) | dm_we_o),
    .waddr (rst ? pl_addr[DAW+1:2] : alu_y[DAW+1:2]),
    .wdata (rst ? pl_data : rt_val),
    .raddr (alu_y[DAW+1:2]),
    .rdata (ld_data)
  );

  // write-back selection
  always_comb begin
    case (ctrl.dst)
      DST_RD:   rf_wa_o = rd;
      DST_LINK: rf_wa_o = LINK_REG;
      default:  rf_wa_o = rt;
    endcase
    case (ctrl.wb)
      WB_MEM:  rf_wd_o = ld_data;
      WB_PC4:  rf_wd_o = pc4;
      default: rf_wd_o = alu_y;
    endcase
  end

  assign rf_we_o   = ~rst & ctrl.reg_we;
  assign dm_re_o   = ~rst & ctrl.mem_rd;
  assign dm_we_o   = ~rst & ctrl.mem_wr;
  assign dm_addr_o = alu_y;
  assign dm_wd_o   = rt_val;

  // next program counter
  assign pc4    = pc_q + XLEN'(4);
  assign br_tgt = pc4 + {simm[XLEN-3:0], 2'b00};
  assign j_tgt  = {pc4[XLEN-1:28], tgt26, 2'b00};

  always_comb begin
    case (ctrl.flow)
      FL_JUMP:   pc_d = j_tgt;
      FL_BRANCH: pc_d = cond ? br_tgt : pc4;
      FL_REG:    pc_d = rs_val;
      default:   pc_d = pc4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // R1
  rst_pc_chk: assert property (@(posedge clk)
    rst |=> pc_q == '0);

  // R10
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.flow == FL_SEQ |=> pc_q == $past(pc_q) + XLEN'(4));

  // R6
  st_nowb_chk: assert property (@(posedge clk) disable iff (rst)
    dm_we_o |-> !rf_we_o && !dm_re_o);

  // R5
  ld_wb_chk: assert property (@(posedge clk) disable iff (rst)
    dm_re_o |-> rf_we_o && rf_wd_o == ld_data);

  // R9
  link_val_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_we_o && ctrl.wb == WB_PC4) |-> rf_wd_o == pc_q + XLEN'(4));
endmodule

// File: tb/sc_core_test.sv
module sc_core_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        pl_we, pl_sel;
  logic [31:0] pl_addr, pl_data;
  logic [31:0] pc_o, rf_wd_o, dm_addr_o, dm_wd_o;
  logic        rf_we_o, dm_re_o, dm_we_o;
  logic [4:0]  rf_wa_o;

  int nchk  = 0;
  int nfail = 0;
  bit live  = 1'b0;
  bit done  = 1'b0;

  typedef struct packed {
    logic [1:0]  kind;   // 0 reg write, 1 mem write, 2 mem read
    logic [31:0] addr;
    logic [31:0] data;
    logic [7:0]  req;
  } exp_t;
  exp_t sb[$];

  logic [31:0] prog [64];

  always #10ns clk = ~clk;

  sc_core uut (
    .clk(clk), .rst(rst), .pl_we(pl_we), .pl_sel(pl_sel),
    .pl_addr(pl_addr), .pl_data(pl_data), .pc_o(pc_o),
    .rf_we_o(rf_we_o), .rf_wa_o(rf_wa_o), .rf_wd_o(rf_wd_o),
    .dm_re_o(dm_re_o), .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o),
    .dm_wd_o(dm_wd_o)
  );

  function automatic logic [31:0] rins(input logic [31:0] fn, rs, rt, rd, sh);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction
  function automatic logic [31:0] iins(input logic [31:0] op, rs, rt, imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] jins(input logic [31:0] op, tgt);
    return {op[5:0], tgt[25:0]};
  endfunction

  task automatic push_reg(input logic [31:0] a, input logic [31:0] d, input int r);
    sb.push_back('{kind: 2'd0, addr: a, data: d, req: 8'(r)});
  endtask
  task automatic push_mem(input logic [31:0] a, input logic [31:0] d, input int r);
    sb.push_back('{kind: 2'd1, addr: a, data: d, req: 8'(r)});
  endtask
  task automatic push_rd(input logic [31:0] a, input int r);
    sb.push_back('{kind: 2'd2, addr: a, data: 32'd0, req: 8'(r)});
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  // monitor: pops and compares each trace event
  task automatic take(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d);
    exp_t e;
    nchk++;
    if (sb.size() == 0) begin
      nfail++;
      $display("FAIL R10: extra event kind %0d addr %h data %h, expected none", k, a, d);
    end else begin
      e = sb.pop_front();
      if (e.kind != k || e.addr != a || (k != 2'd2 && e.data != d)) begin
        nfail++;
        $display("FAIL R%0d: kind %0d addr %h data %h, expected kind %0d addr %h data %h",
                 e.req, k, a, d, e.kind, e.addr, e.data);
      end
    end
  endtask

  always @(negedge clk) begin
    if (live && !rst) begin
      if (dm_re_o) take(2'd2, dm_addr_o, 32'd0);
      if (dm_we_o) take(2'd1, dm_addr_o, dm_wd_o);
      if (rf_we_o) take(2'd0, {27'd0, rf_wa_o}, rf_wd_o);
    end
  end

  task automatic build;
    for (int i = 0; i < 64; i++) prog[i] = 32'd0;
    prog[0]  = iins(35, 0, 1, 0);            // lw r1,0(r0)
    prog[1]  = iins(35, 0, 2, 4);            // lw r2,4(r0)
    prog[2]  = rins(32, 1, 2, 3, 0);         // add
    prog[3]  = rins(34, 1, 2, 4, 0);         // sub
    prog[4]  = rins(36, 1, 2, 5, 0);         // and
    prog[5]  = rins(37, 1, 2, 6, 0);         // or
    prog[6]  = rins(38, 1, 2, 7, 0);         // xor
    prog[7]  = rins(39, 1, 2, 8, 0);         // nor
    prog[8]  = rins(42, 2, 1, 9, 0);         // slt
    prog[9]  = rins(43, 2, 1, 10, 0);        // sltu
    prog[10] = rins(0, 0, 1, 11, 4);         // sll
    prog[11] = rins(2, 0, 2, 12, 4);         // srl
    prog[12] = rins(3, 0, 2, 13, 4);         // sra
    prog[13] = iins(8, 0, 14, 32'hFFFD);     // addi -3
    prog[14] = iins(10, 14, 15, 32'hFFFE);   // slti -2
    prog[15] = iins(12, 1, 16, 32'hFF0F);    // andi
    prog[16] = iins(13, 0, 17, 32'h7000);    // ori
    prog[17] = iins(14, 1, 18, 32'h00FF);    // xori
    prog[18] = iins(15, 0, 19, 32'hABCD);    // lui
    prog[19] = iins(8, 0, 0, 7);             // addi r0
    prog[20] = rins(32, 0, 0, 20, 0);        // add r20,r0,r0
    prog[21] = iins(43, 0, 3, 8);            // sw r3,8
    prog[22] = iins(43, 0, 19, 12);          // sw r19,12
    prog[23] = iins(35, 0, 21, 8);           // lw r21,8
    prog[24] = iins(4, 21, 3, 1);            // beq taken
    prog[25] = iins(8, 0, 22, 1);
    prog[26] = iins(5, 21, 3, 1);            // bne not taken
    prog[27] = iins(8, 0, 22, 2);
    prog[28] = iins(6, 14, 0, 1);            // blez taken
    prog[29] = iins(8, 0, 23, 1);
    prog[30] = iins(7, 14, 0, 1);            // bgtz not taken
    prog[31] = iins(8, 0, 23, 3);
    prog[32] = iins(6, 0, 0, 1);             // blez on zero, taken
    prog[33] = iins(8, 0, 24, 1);
    prog[34] = iins(7, 22, 0, 1);            // bgtz taken
    prog[35] = iins(8, 0, 24, 1);
    prog[36] = jins(3, 40);                  // jal
    prog[37] = iins(8, 0, 25, 1);
    prog[40] = iins(8, 0, 26, 176);
    prog[41] = rins(9, 26, 0, 27, 0);        // jalr r27,r26
    prog[42] = iins(8, 0, 25, 9);
    prog[44] = iins(8, 0, 28, 196);
    prog[45] = rins(8, 28, 0, 0, 0);         // jr r28
    prog[46] = iins(8, 0, 25, 1);
    prog[49] = jins(2, 51);                  // j
    prog[50] = iins(8, 0, 25, 1);
    prog[51] = iins(4, 0, 0, 32'hFFFF);      // beq back onto itself
  endtask

  task automatic expect_all;
    push_rd(0, 5);  push_reg(1, 32'h0000_1234, 5);          // R5
    push_rd(4, 5);  push_reg(2, 32'hFFFF_FFF0, 5);          // R5
    push_reg(3, 32'h0000_1224, 2);                          // R2
    push_reg(4, 32'h0000_1244, 2);
    push_reg(5, 32'h0000_1230, 2);
    push_reg(6, 32'hFFFF_FFF4, 2);
    push_reg(7, 32'hFFFF_EDC4, 2);
    push_reg(8, 32'h0000_000B, 2);
    push_reg(9, 32'h0000_0001, 2);
    push_reg(10, 32'h0000_0000, 2);
    push_reg(11, 32'h0001_2340, 2);
    push_reg(12, 32'h0FFF_FFFF, 2);
    push_reg(13, 32'hFFFF_FFFF, 2);
    push_reg(14, 32'hFFFF_FFFD, 3);                         // R3
    push_reg(15, 32'h0000_0001, 3);
    push_reg(16, 32'h0000_1204, 3);
    push_reg(17, 32'h0000_7000, 3);
    push_reg(18, 32'h0000_12CB, 3);
    push_reg(19, 32'hABCD_0000, 3);
    push_reg(0, 32'h0000_0007, 4);                          // R4 attempt
    push_reg(20, 32'h0000_0000, 4);                         // R4 reads zero
    push_mem(8, 32'h0000_1224, 6);                          // R6
    push_mem(12, 32'hABCD_0000, 6);
    push_rd(8, 5);  push_reg(21, 32'h0000_1224, 5);         // R5
    push_reg(22, 32'd2, 7);                                 // R7
    push_reg(23, 32'd3, 7);
    push_reg(31, 32'h0000_0094, 8);                         // R8
    push_reg(26, 32'd176, 9);                               // R9
    push_reg(27, 32'h0000_00A8, 9);
    push_reg(28, 32'd196, 9);
  endtask

  initial begin
    rst = 1'b1; pl_we = 1'b0; pl_sel = 1'b0; pl_addr = '0; pl_data = '0;
    build();
    expect_all();
    repeat (2) @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      pl_we = 1'b1; pl_sel = 1'b0; pl_addr = 32'(i * 4); pl_data = prog[i];
      @(negedge clk);
    end
    for (int i = 0; i < 64; i++) begin
      pl_we = 1'b1; pl_sel = 1'b1; pl_addr = 32'(i * 4);
      pl_data = (i == 0) ? 32'h0000_1234 : (i == 1) ? 32'hFFFF_FFF0 : 32'd0;
      @(negedge clk);
    end
    pl_we = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(pc_o == 32'd0, "R1 pc", pc_o, 32'd0);
    check({rf_we_o, dm_re_o, dm_we_o} == 3'b000, "R1 strobes",
          {29'd0, rf_we_o, dm_re_o, dm_we_o}, 32'd0);
    @(posedge clk);
    #1 rst = 1'b0; live = 1'b1;
    repeat (80) @(negedge clk);
    #1;
    live = 1'b0;
    // R10: every predicted event seen
    check(sb.size() == 0, "R10 pending", 32'(sb.size()), 32'd0);
    // R8 / R7: parked on the backward self-branch after the jump
    check(pc_o == 32'd204, "R8 final pc", pc_o, 32'd204);
    check(!rf_we_o && !dm_we_o, "R7 idle loop", {30'd0, rf_we_o, dm_we_o}, 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL R10: watchdog expired, got pc %h expected completion", pc_o);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule